// File: doc/BRIEF.md
# Table Waveform Generator Channel

This block drives one channel of an arbitrary waveform generator. A sample table of signed 14-bit entries is swept by a fixed-point phase accumulator that has 16 fractional bits. The integer part of the accumulator picks the table entry. Each entry read from the table is multiplied by an unsigned gain, where code 0x2000 means unity. A signed offset is then added, and the result is clamped to the signed 14-bit range before it appears at the output. The accumulator adds a programmable step on every clock while the channel plays. When the sum reaches the wrap value, the accumulator either subtracts the wrap value, which keeps the fractional phase, or reloads the start offset.

A burst sequencer decides when the channel plays. It waits in idle for a trigger, which is immediate, a rising edge or a falling edge of an external line. It then plays a programmed number of table passes per burst. After the burst it either stops, or waits a number of microsecond ticks and plays the next burst. The table is loaded through a write port. Two control inputs are provided: one forces the output to zero and the other returns the sequencer to idle.

Top module: `wavegen_channel`

## Requirements
- R1: While reset is asserted and just after it, `sampleOut` is 0 and `readPtr` is 0.
- R2: The accumulator has 16 fractional bits, and `readPtr` is its integer part. While the channel plays, the accumulator grows by `stepVal` on each clock. The table entry addressed at clock k drives `sampleOut` after the edge of clock k+2.
- R3: With `wrapMode`=1, when accumulator+step is at least `wrapVal`, the new value is accumulator+step−`wrapVal`, so the fractional phase is kept.
- R4: With `wrapMode`=0, the same condition reloads the accumulator with `startOfs`.
- R5: The `trigSel` codes are: 1 fires at once, 2 fires on a rising edge of `extTrig`, and 3 fires on a falling edge. Any other code never fires. A trigger is accepted only in idle, and it loads `startOfs` into the accumulator.
- R6: The output is floor(sample×gain/8192)+offset. The sample and the offset are signed 14-bit values, and the gain is unsigned 14-bit. A gain of 0x2000 passes the sample unchanged.
- R7: A result above 8191 or below −8192 is clamped to that limit.
- R8: `passCount`=N, where N is not 0, ends the burst at the wrap that completes pass N. N=0 plays without end.
- R9: `burstCount`=M plays M further bursts after the first. M=0 means a single burst.
- R10: Between bursts the accumulator holds and the output is 0 until `burstDelay` pulses of `usTick` have been counted. The start offset is then reloaded and playing resumes.
- R11: After the last burst the sequencer is idle: the output is 0, `readPtr` holds, and a new trigger is needed to play again.
- R12: `forceZero` at a clock edge makes `sampleOut` 0 after that edge. The accumulator keeps running.
- R13: `smReset` returns the sequencer to idle at the next edge and blocks triggers while it is held.
- R14: With `tblWe` set, `tblData` is written into table entry `tblAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigSel | input | 4 | Trigger source code |
| extTrig | input | 1 | External trigger line |
| usTick | input | 1 | One-cycle pulse every microsecond |
| smReset | input | 1 | Return sequencer to idle |
| forceZero | input | 1 | Force output to zero |
| wrapMode | input | 1 | 1: subtract wrap value, 0: reload start offset |
| startOfs | input | ADDR_W+16 | Accumulator start value |
| stepVal | input | ADDR_W+16 | Accumulator increment |
| wrapVal | input | ADDR_W+16 | Accumulator wrap threshold |
| gain | input | 14 | Unsigned gain, 0x2000 is unity |
| offset | input | 14 | Signed output offset |
| passCount | input | 16 | Table passes per burst, 0 is endless |
| burstCount | input | 16 | Extra bursts after the first |
| burstDelay | input | 32 | Gap between bursts in microsecond ticks |
| tblWe | input | 1 | Table write enable |
| tblAddr | input | ADDR_W | Table write address |
| tblData | input | 14 | Table write data |
| sampleOut | output | 14 | Scaled, clamped sample |
| readPtr | output | ADDR_W | Integer part of the accumulator |

## Verification
The hardest situation to reach from the ports is the boundary between bursts. There the last wrap of the final pass has to hand over to the tick-counted gap, and the gap then has to hand over to a fresh start-offset reload while the two-stage output pipeline drains. The bench makes passes only a few entries long and pulses `usTick` on every fourth clock. It runs multi-burst sequences with gaps of zero and three ticks. A cycle-level model built from the requirements predicts every pointer and sample value through those transitions. Gain and offset are swept across the full table, including the table's extreme entries, so that both clamping limits are hit.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;
  localparam int FRAC_W      = 16;
  localparam int SAMPLE_W    = 14;
  localparam int UNITY_SHIFT = 13;
  localparam int COUNT_W     = 16;
  localparam int DELAY_W     = 32;

  localparam logic [3:0] TRIG_NOW  = 4'd1;
  localparam logic [3:0] TRIG_RISE = 4'd2;
  localparam logic [3:0] TRIG_FALL = 4'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PLAY = 2'd1,
    SEQ_GAP  = 2'd2
  } seqState_e;

  typedef struct packed {
    logic loadStart;
    logic advance;
  } dpStrobes_t;
endpackage

// File: rtl/wavegen_datapath.sv
module wavegen_datapath
  import wavegen_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobes_t                 strb,
  input  logic                       wrapMode,
  input  logic                       forceZero,
  input  logic [ADDR_W+FRAC_W-1:0]   startOfs,
  input  logic [ADDR_W+FRAC_W-1:0]   stepVal,
  input  logic [ADDR_W+FRAC_W-1:0]   wrapVal,
  input  logic [SAMPLE_W-1:0]        gain,
  input  logic [SAMPLE_W-1:0]        offset,
  input  logic                       tblWe,
  input  logic [ADDR_W-1:0]          tblAddr,
  input  logic [SAMPLE_W-1:0]        tblData,
  output logic                       wrapHit,
  output logic [ADDR_W+FRAC_W-1:0]   accOut,
  output logic [ADDR_W-1:0]          readPtr,
  output logic [SAMPLE_W-1:0]        sampleOut
);
  localparam int ACC_W  = ADDR_W + FRAC_W;
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int PROD_W = 2 * SAMPLE_W + 1;
  localparam int EXT_W  = PROD_W - SAMPLE_W + 2;
  localparam logic signed [PROD_W:0] SAT_HI = {{EXT_W{1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PROD_W:0] SAT_LO = {{EXT_W{1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic [ACC_W-1:0]    acc;
  logic [ACC_W:0]      nextSum;
  logic [ACC_W-1:0]    wrapped;
  logic [SAMPLE_W-1:0] sampleMem [DEPTH];
  logic [SAMPLE_W-1:0] rdData;
  logic                enStage1;

  logic signed [PROD_W-1:0]   product;
  logic signed [PROD_W:0]     sumVal;
  logic signed [SAMPLE_W-1:0] satVal;

  // phase accumulator
  always_comb begin
    nextSum = {1'b0, acc} + {1'b0, stepVal};
    wrapped = nextSum[ACC_W-1:0] - wrapVal;
    wrapHit = strb.advance && (nextSum >= {1'b0, wrapVal});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strb.loadStart) begin
      acc <= startOfs;
    end else if (strb.advance) begin
      if (wrapHit) acc <= wrapMode ? wrapped : startOfs;
      else         acc <= nextSum[ACC_W-1:0];
    end
  end

  assign readPtr = acc[ACC_W-1:FRAC_W];
  assign accOut  = acc;

  // sample table, registered read
  always_ff @(posedge clk) begin
    if (tblWe) sampleMem[tblAddr] <= tblData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      enStage1 <= 1'b0;
    end else begin
      rdData   <= sampleMem[readPtr];
      enStage1 <= strb.advance;
    end
  end

  // gain, offset and clamp
  always_comb begin
    product = $signed(rdData) * $signed({1'b0, gain});
    sumVal  = (PROD_W+1)'(product >>> UNITY_SHIFT) + (PROD_W+1)'($signed(offset));
    if (sumVal > SAT_HI)      satVal = SAT_HI[SAMPLE_W-1:0];
    else if (sumVal < SAT_LO) satVal = SAT_LO[SAMPLE_W-1:0];
    else                      satVal = sumVal[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        sampleOut <= '0;
    else if (enStage1 && !forceZero)  sampleOut <= satVal;
    else                              sampleOut <= '0;
  end
endmodule

// File: rtl/wavegen_control.sv
module wavegen_control
  import wavegen_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         trigSel,
  input  logic               extTrig,
  input  logic               usTick,
  input  logic               smReset,
  input  logic [COUNT_W-1:0] passCount,
  input  logic [COUNT_W-1:0] burstCount,
  input  logic [DELAY_W-1:0] burstDelay,
  input  logic               wrapHit,
  output dpStrobes_t         strb
);
  seqState_e          seqState;
  logic               extPrev;
  logic               trigEvent;
  logic               burstEnd;
  logic               gapDone;
  logic [COUNT_W-1:0] passIdx;
  logic [COUNT_W-1:0] repIdx;
  logic [DELAY_W-1:0] gapCnt;

  always_comb begin
    case (trigSel)
      TRIG_NOW:  trigEvent = 1'b1;
      TRIG_RISE: trigEvent = extTrig && !extPrev;
      TRIG_FALL: trigEvent = !extTrig && extPrev;
      default:   trigEvent = 1'b0;
    endcase
  end

  assign burstEnd = wrapHit && (passCount != '0) && ((passIdx + 1'b1) == passCount);
  assign gapDone  = (seqState == SEQ_GAP) && (gapCnt == burstDelay);

  always_comb begin
    strb.loadStart = !smReset && (((seqState == SEQ_IDLE) && trigEvent) || gapDone);
    strb.advance   = !smReset && (seqState == SEQ_PLAY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extTrig;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SEQ_IDLE;
      passIdx  <= '0;
      repIdx   <= '0;
      gapCnt   <= '0;
    end else if (smReset) begin
      seqState <= SEQ_IDLE;
      passIdx  <= '0;
      repIdx   <= '0;
      gapCnt   <= '0;
    end else begin
      case (seqState)
        SEQ_IDLE: begin
          if (trigEvent) begin
            seqState <= SEQ_PLAY;
            passIdx  <= '0;
            repIdx   <= '0;
          end
        end
        SEQ_PLAY: begin
          if (burstEnd) begin
            passIdx <= '0;
            if (repIdx != burstCount) begin
              repIdx   <= repIdx + 1'b1;
              gapCnt   <= '0;
              seqState <= SEQ_GAP;
            end else begin
              seqState <= SEQ_IDLE;
            end
          end else if (wrapHit) begin
            passIdx <= passIdx + 1'b1;
          end
        end
        SEQ_GAP: begin
          if (gapDone) begin
            seqState <= SEQ_PLAY;
            passIdx  <= '0;
          end else if (usTick) begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: seqState <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wavegen_channel.sv
module wavegen_channel
  import wavegen_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [3:0]                trigSel,
  input  logic                      extTrig,
  input  logic                      usTick,
  input  logic                      smReset,
  input  logic                      forceZero,
  input  logic                      wrapMode,
  input  logic [ADDR_W+FRAC_W-1:0]  startOfs,
  input  logic [ADDR_W+FRAC_W-1:0]  stepVal,
  input  logic [ADDR_W+FRAC_W-1:0]  wrapVal,
  input  logic [SAMPLE_W-1:0]       gain,
  input  logic [SAMPLE_W-1:0]       offset,
  input  logic [COUNT_W-1:0]        passCount,
  input  logic [COUNT_W-1:0]        burstCount,
  input  logic [DELAY_W-1:0]        burstDelay,
  input  logic                      tblWe,
  input  logic [ADDR_W-1:0]         tblAddr,
  input  logic [SAMPLE_W-1:0]       tblData,
  output logic [SAMPLE_W-1:0]       sampleOut,
  output logic [ADDR_W-1:0]         readPtr
);
  localparam int ACC_W = ADDR_W + FRAC_W;

  dpStrobes_t       strb;
  logic             wrapHit;
  logic [ACC_W-1:0] accOut;

  wavegen_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .trigSel    (trigSel),
    .extTrig    (extTrig),
    .usTick     (usTick),
    .smReset    (smReset),
    .passCount  (passCount),
    .burstCount (burstCount),
    .burstDelay (burstDelay),
    .wrapHit    (wrapHit),
    .strb       (strb)
  );

  wavegen_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrapMode  (wrapMode),
    .forceZero (forceZero),
    .startOfs  (startOfs),
    .stepVal   (stepVal),
    .wrapVal   (wrapVal),
    .gain      (gain),
    .offset    (offset),
    .tblWe     (tblWe),
    .tblAddr   (tblAddr),
    .tblData   (tblData),
    .wrapHit   (wrapHit),
    .accOut    (accOut),
    .readPtr   (readPtr),
    .sampleOut (sampleOut)
  );
endmodule

// File: rtl/wavegen_channel_checker.sv
module wavegen_channel_checker #(
  parameter int ACC_W = 24,
  parameter int SMP_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadStart,
  input logic             advance,
  input logic             wrapHit,
  input logic             smReset,
  input logic             forceZero,
  input logic             wrapMode,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] stepVal,
  input logic [ACC_W-1:0] wrapVal,
  input logic [ACC_W-1:0] startOfs,
  input logic [SMP_W-1:0] sampleOut
);
  p_load_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadStart |=> acc == $past(startOfs));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadStart, advance}));

  p_step_add_r2: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !wrapHit) |=> acc == ACC_W'($past(acc) + $past(stepVal)));

  p_wrap_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (advance && wrapHit && wrapMode) |=>
      acc == ACC_W'($past(acc) + $past(stepVal) - $past(wrapVal)));

  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (advance && wrapHit && !wrapMode) |=> acc == $past(startOfs));

  p_hold_still_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !loadStart) |=> $stable(acc));

  p_force_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    forceZero |=> sampleOut == '0);

  p_seq_reset_r13: assert property (@(posedge clk) disable iff (!rstN)
    smReset |=> !advance);
endmodule

bind wavegen_channel wavegen_channel_checker #(
  .ACC_W (ACC_W),
  .SMP_W (wavegen_pkg::SAMPLE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadStart (strb.loadStart),
  .advance   (strb.advance),
  .wrapHit   (wrapHit),
  .smReset   (smReset),
  .forceZero (forceZero),
  .wrapMode  (wrapMode),
  .acc       (accOut),
  .stepVal   (stepVal),
  .wrapVal   (wrapVal),
  .startOfs  (startOfs),
  .sampleOut (sampleOut)
);

// File: tb/wavegen_channel_tb.sv
`timescale 1ns/1ps
module wavegen_channel_tb;
  localparam int AW = 8;
  localparam int CW = AW + 16;
  localparam int DEPTH = 2 ** AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    trigSel = '0;
  logic          extTrig = 1'b0;
  logic          usTick = 1'b0;
  logic          smReset = 1'b0;
  logic          forceZero = 1'b0;
  logic          wrapMode = 1'b0;
  logic [CW-1:0] startOfs = '0;
  logic [CW-1:0] stepVal = '0;
  logic [CW-1:0] wrapVal = '0;
  logic [13:0]   gain = 14'h2000;
  logic [13:0]   offset = '0;
  logic [15:0]   passCount = '0;
  logic [15:0]   burstCount = '0;
  logic [31:0]   burstDelay = '0;
  logic          tblWe = 1'b0;
  logic [AW-1:0] tblAddr = '0;
  logic [13:0]   tblData = '0;
  logic [13:0]   sampleOut;
  logic [AW-1:0] readPtr;

  wavegen_channel #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .trigSel(trigSel), .extTrig(extTrig), .usTick(usTick),
    .smReset(smReset), .forceZero(forceZero), .wrapMode(wrapMode), .startOfs(startOfs),
    .stepVal(stepVal), .wrapVal(wrapVal), .gain(gain), .offset(offset),
    .passCount(passCount), .burstCount(burstCount), .burstDelay(burstDelay),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData),
    .sampleOut(sampleOut), .readPtr(readPtr)
  );

  always #2.5 clk = ~clk;

  int    nChecks = 0;
  int    nFails = 0;
  bit    chkOn = 1'b0;
  string ptrTag = "R2";
  string outTag = "R6";
  int    tbl [DEPTH];

  // reference model state
  longint mAcc, mGap, nxt;
  int     mSt, mPass, mRep, mRd, mOut, newOut;
  bit     mPrev, mEn1, trigEv, ldS, adv, hit;

  function automatic int tblVal(int i);
    if (i == 0) return -8192;
    if (i == 1) return 8191;
    return ((i * 1237 + 311) % 16384) - 8192;
  endfunction

  function automatic int expOut(int d, int g, int o);
    longint p = longint'(d) * longint'(g);
    longint s = (p >>> 13) + o;
    if (s > 8191) s = 8191;
    if (s < -8192) s = -8192;
    return int'(s);
  endfunction

  task automatic chk(input int act, input int exp, input string tag, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAcc = 0; mGap = 0; mSt = 0; mPass = 0; mRep = 0;
      mRd = 0; mOut = 0; mPrev = 0; mEn1 = 0;
    end else begin
      trigEv = (trigSel == 4'd1) || (trigSel == 4'd2 && extTrig && !mPrev) ||
               (trigSel == 4'd3 && !extTrig && mPrev);
      ldS = !smReset && ((mSt == 0 && trigEv) || (mSt == 2 && mGap == longint'(burstDelay)));
      adv = !smReset && (mSt == 1);
      nxt = mAcc + longint'(stepVal);
      hit = adv && (nxt >= longint'(wrapVal));
      newOut = (mEn1 && !forceZero) ? expOut(mRd, int'(gain), int'($signed(offset))) : 0;
      mRd = tbl[int'(mAcc >> 16)];
      mEn1 = adv;
      mOut = newOut;
      if (ldS) mAcc = longint'(startOfs);
      else if (adv) begin
        if (hit) mAcc = wrapMode ? (nxt - longint'(wrapVal)) : longint'(startOfs);
        else     mAcc = nxt;
      end
      if (smReset) begin
        mSt = 0; mPass = 0; mRep = 0; mGap = 0;
      end else begin
        case (mSt)
          0: if (trigEv) begin mSt = 1; mPass = 0; mRep = 0; end
          1: if (hit) begin
               if (passCount != 0 && mPass + 1 == int'(passCount)) begin
                 mPass = 0;
                 if (mRep != int'(burstCount)) begin mRep++; mSt = 2; mGap = 0; end
                 else mSt = 0;
               end else mPass++;
             end
          default: begin
            if (mGap == longint'(burstDelay)) begin mSt = 1; mPass = 0; end
            else if (usTick) mGap++;
          end
        endcase
      end
      mPrev = extTrig;
    end
  end

  always @(negedge clk) begin
    if (chkOn) begin
      chk(int'(readPtr), int'(mAcc >> 16), ptrTag, "readPtr");
      chk(int'($signed(sampleOut)), mOut, outTag, "sampleOut");
    end
  end

  // microsecond tick: one pulse every fourth clock
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      usTick = 1'b1;
      @(negedge clk);
      usTick = 1'b0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    smReset = 1'b1;
    cyc(1);
    smReset = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int gains[5];
    int offs[5];
    gains = '{0, 14'h1000, 14'h2000, 14'h2001, 14'h3FFF};
    offs  = '{0, -100, 100, 8191, -8192};

    // R1: reset state
    cyc(3);
    chk(int'(sampleOut), 0, "R1", "sampleOut in reset");
    chk(int'(readPtr), 0, "R1", "readPtr in reset");
    rstN = 1'b1;
    cyc(1);
    chk(int'(sampleOut), 0, "R1", "sampleOut after reset");
    chk(int'(readPtr), 0, "R1", "readPtr after reset");
    chkOn = 1'b1;

    // R14: load table
    for (int i = 0; i < DEPTH; i++) begin
      tbl[i] = tblVal(i);
      tblWe = 1'b1; tblAddr = AW'(i); tblData = 14'(tbl[i]);
      cyc(1);
    end
    tblWe = 1'b0;
    cyc(2);

    // R2 / R14: unity playback of the whole table
    ptrTag = "R2"; outTag = "R14";
    wrapMode = 1'b0; startOfs = '0; stepVal = CW'(32'h10000); wrapVal = '1;
    gain = 14'h2000; offset = '0; passCount = '0;
    trigSel = 4'd1;
    cyc(DEPTH + 20);

    // R3: fractional step, subtract wrap
    restart();
    ptrTag = "R3"; outTag = "R2";
    wrapMode = 1'b1; startOfs = CW'(32'h20000); stepVal = CW'(32'h18000); wrapVal = CW'(32'hA8000);
    cyc(80);

    // R4: reload start offset on wrap
    restart();
    ptrTag = "R4";
    wrapMode = 1'b0; startOfs = CW'(32'h30000); stepVal = CW'(32'h14000); wrapVal = CW'(32'h90000);
    cyc(80);

    // R6 / R7: gain and offset sweep across whole table
    wrapMode = 1'b0; startOfs = '0; stepVal = CW'(32'h10000); wrapVal = '1;
    for (int g = 0; g < 5; g++) begin
      for (int o = 0; o < 5; o++) begin
        restart();
        gain = 14'(gains[g]); offset = 14'(offs[o]);
        outTag = (g == 4 || o >= 3) ? "R7" : "R6";
        cyc(DEPTH + 4);
      end
    end
    gain = 14'h2000; offset = '0;

    // R12: force to zero while playing
    outTag = "R12";
    forceZero = 1'b1;
    cyc(12);
    chk(int'(sampleOut), 0, "R12", "forced output");
    forceZero = 1'b0;
    cyc(6);

    // R13: sequencer reset held with immediate trigger
    outTag = "R13"; ptrTag = "R13";
    smReset = 1'b1;
    cyc(10);
    chk(int'(sampleOut), 0, "R13", "output under sequencer reset");
    smReset = 1'b0;
    cyc(4);

    // R5 / R8 / R11: external edges, limited passes, back to idle
    trigSel = 4'd0;
    restart();
    ptrTag = "R5"; outTag = "R8";
    wrapMode = 1'b1; startOfs = CW'(32'h08000); stepVal = CW'(32'h10000); wrapVal = CW'(32'h40000);
    passCount = 16'd3; burstCount = '0; burstDelay = '0;
    extTrig = 1'b1; cyc(3); extTrig = 1'b0; cyc(5);
    trigSel = 4'd7;
    cyc(10);
    trigSel = 4'd2;
    cyc(3);
    extTrig = 1'b1; cyc(4); extTrig = 1'b0; cyc(3); extTrig = 1'b1;
    outTag = "R11";
    cyc(20);
    chk(int'(sampleOut), 0, "R11", "idle output after last pass");
    trigSel = 4'd3;
    cyc(3);
    ptrTag = "R5";
    extTrig = 1'b0;
    cyc(20);
    extTrig = 1'b1; cyc(2); extTrig = 1'b0;
    cyc(20);

    // R8: endless passes
    outTag = "R8";
    passCount = '0;
    trigSel = 4'd0;
    restart();
    trigSel = 4'd1;
    cyc(40);

    // R9 / R10: multi-burst with gaps
    trigSel = 4'd0;
    restart();
    ptrTag = "R9"; outTag = "R10";
    wrapMode = 1'b0; startOfs = CW'(32'h10000); stepVal = CW'(32'h10000); wrapVal = CW'(32'h40000);
    passCount = 16'd2; burstCount = 16'd2; burstDelay = 32'd3;
    trigSel = 4'd2;
    extTrig = 1'b1; cyc(1); extTrig = 1'b0;
    cyc(90);
    burstDelay = 32'd0;
    ptrTag = "R10";
    extTrig = 1'b1; cyc(1); extTrig = 1'b0;
    cyc(60);
    chk(int'(sampleOut), 0, "R11", "idle after final burst");

    chkOn = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule